// File: doc/BRIEF.md
# Register-Designator Interrupt and Linkage Controller

This block holds the two 4-bit designators that pick which of sixteen external 16-bit registers currently acts as the program counter (P) and which one acts as the data pointer (X). It also holds an 8-bit save byte (T) and an interrupt enable flag (IE). The processor has no push-style call. Subroutine linkage and interrupt entry work by changing which register plays each role. The old pair of designators is packed into one byte, {X,P} with X in the upper nibble, and that byte is kept in T or in memory.

An instruction sequencer offers an opcode on `op_i` with `op_valid_i`. The opcode is taken in a cycle where `op_ready_o` is high. Memory is reached through a command port. The block names the register whose contents form the address (`mem_reg_o`) and raises a one-cycle read or write strobe. Read data is returned on `mem_rdata_i` in the cycle after the read strobe. Increments and decrements of the external register file are requested with `reg_idx_o` and one-cycle strobes. Operations that touch memory run through a short sequence with `busy_o` high, so memory accesses and pointer updates happen in a fixed order.

Top module: `pxlink_ctrl`

## Requirements
- R1: Synchronous active-high reset sets P and X to 0, T to 0 and IE to 1, and leaves `busy_o` and all four strobes low.
- R2: A set-P opcode (upper nibble 0xD) loads P with the lower nibble, and a set-X opcode (upper nibble 0xE) loads X with the lower nibble. Each takes effect at the clock edge that accepts it, and `busy_o` never rises.
- R3: Interrupt entry, in one clock edge: T takes the old {X,P} (X in bits 7:4), P becomes 1, X becomes 2 and IE becomes 0. No strobe is issued.
- R4: Opcode 0x79 (link) sets T to the old {X,P}. It then writes that byte through register 2 for one cycle, then decrements register 2 for one cycle, with X set to P at the end of the write cycle. `busy_o` is high for exactly 2 cycles.
- R5: Opcode 0x78 (save) writes T through register X for one cycle. P, X, T and IE are unchanged, and `busy_o` is high for exactly 1 cycle.
- R6: Opcodes 0x70 (return) and 0x71 (return-disabled) read through register X for one cycle, then increment that same register for one cycle. At the end of the increment cycle they load {X,P} from the returned byte and set IE to 1 (0x70) or 0 (0x71). `busy_o` is high for exactly 2 cycles.
- R7: An interrupt request is taken only while IE is 1 and no operation is in progress. A request held while IE is 0 changes nothing, and a request raised during a busy sequence is taken on the first idle cycle after it.
- R8: When an interrupt is taken, `op_ready_o` is low in that cycle and the offered opcode is not consumed. It is accepted in a later cycle.
- R9: Any other opcode is consumed with no effect: no strobe, no `busy_o`, and P, X, T and IE unchanged.
- R10: At most one of the four command strobes is high in any cycle, and `op_ready_o` is low whenever `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 1 | Interrupt request level |
| op_valid_i | input | 1 | Opcode offered |
| op_i | input | 8 | Opcode: upper nibble class, lower nibble register number |
| op_ready_o | output | 1 | Opcode accepted in this cycle when valid |
| busy_o | output | 1 | Multi-cycle sequence in progress |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_reg_o | output | 4 | Register whose contents address the access |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the read strobe |
| reg_idx_o | output | 4 | Register to increment or decrement |
| reg_inc_o | output | 1 | Increment strobe |
| reg_dec_o | output | 1 | Decrement strobe |
| p_o | output | 4 | Program-counter designator |
| x_o | output | 4 | Data-pointer designator |
| t_o | output | 8 | Save byte |
| ie_o | output | 1 | Interrupt enable |

## Verification
The properties check on every cycle that the strobes never overlap, that a decrement always follows a write through the same register, and that an increment always follows a read through the same register. They also check that an enabled request at an idle boundary produces the fixed entry state, and that an idle, masked, opcode-free cycle leaves the designators alone. Only the bench scenarios show the values that are written and loaded: the packed byte a link writes, the designators recovered from a returned byte, and the IE value chosen by each return flavour. The scenarios also cover the hold-off of a request raised mid-sequence and the deferral of an opcode offered together with an interrupt.

// File: rtl/pxl_pkg.sv
package pxl_pkg;

  // Decoded operation classes.
  typedef enum logic [2:0] {
    OP_NONE,
    OP_SEP,
    OP_SEX,
    OP_MARK,
    OP_SAV,
    OP_RET,
    OP_DIS
  } op_kind_t;

  // Sequencer states.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_DEC,
    ST_RD,
    ST_INC
  } seq_st_t;

  // Upper-nibble opcode classes.
  localparam logic [3:0] HI_SETP = 4'hD;
  localparam logic [3:0] HI_SETX = 4'hE;
  localparam logic [3:0] HI_CTRL = 4'h7;

  // Lower-nibble selectors inside the control class.
  localparam int LO_RET  = 0;
  localparam int LO_DIS  = 1;
  localparam int LO_SAV  = 8;
  localparam int LO_MARK = 9;

endpackage

// File: rtl/pxl_decode.sv
module pxl_decode
  import pxl_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic [NIB_W+3:0] op_i,
  output op_kind_t         kind_o,
  output logic [NIB_W-1:0] n_o
);

  logic [3:0]       hi;
  logic [NIB_W-1:0] lo;

  assign hi  = op_i[NIB_W+3 -: 4];
  assign lo  = op_i[NIB_W-1:0];
  assign n_o = lo;

  always_comb begin
    kind_o = OP_NONE;
    if (hi == HI_SETP) begin
      kind_o = OP_SEP;
    end else if (hi == HI_SETX) begin
      kind_o = OP_SEX;
    end else if (hi == HI_CTRL) begin
      if (lo == NIB_W'(LO_RET))       kind_o = OP_RET;
      else if (lo == NIB_W'(LO_DIS))  kind_o = OP_DIS;
      else if (lo == NIB_W'(LO_SAV))  kind_o = OP_SAV;
      else if (lo == NIB_W'(LO_MARK)) kind_o = OP_MARK;
      else                            kind_o = OP_NONE;
    end
  end

endmodule

// File: rtl/pxl_regs.sv
module pxl_regs #(
  parameter int NIB_W  = 4,
  parameter int INT_P  = 1,
  parameter int INT_X  = 2,
  parameter bit RST_IE = 1'b1,
  localparam int DATA_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_int,
  input  logic              ld_p,
  input  logic              ld_x,
  input  logic              mark_t,
  input  logic              mark_x,
  input  logic              ret_ld,
  input  logic              ret_ie,
  input  logic [NIB_W-1:0]  n_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [NIB_W-1:0]  p_o,
  output logic [NIB_W-1:0]  x_o,
  output logic [DATA_W-1:0] t_o,
  output logic              ie_o
);

  localparam logic [NIB_W-1:0] INT_P_V = NIB_W'(INT_P);
  localparam logic [NIB_W-1:0] INT_X_V = NIB_W'(INT_X);

  always_ff @(posedge clk) begin
    if (rst) begin
      p_o  <= '0;
      x_o  <= '0;
      t_o  <= '0;
      ie_o <= RST_IE;
    end else if (ld_int) begin
      // Entry: old pair saved, fixed designators, further entries masked.
      t_o  <= {x_o, p_o};
      p_o  <= INT_P_V;
      x_o  <= INT_X_V;
      ie_o <= 1'b0;
    end else begin
      if (ld_p)   p_o <= n_i;
      if (ld_x)   x_o <= n_i;
      if (mark_t) t_o <= {x_o, p_o};
      if (mark_x) x_o <= p_o;
      if (ret_ld) begin
        {x_o, p_o} <= rdata_i;
        ie_o       <= ret_ie;
      end
    end
  end

endmodule

// File: rtl/pxl_seq.sv
module pxl_seq
  import pxl_pkg::*;
#(
  parameter int NIB_W     = 4,
  parameter int STACK_REG = 2,
  localparam int DATA_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid_i,
  input  op_kind_t          kind_i,
  input  logic              irq_i,
  input  logic              ie_i,
  input  logic [NIB_W-1:0]  p_i,
  input  logic [NIB_W-1:0]  x_i,
  input  logic [DATA_W-1:0] t_i,
  output logic              op_ready_o,
  output logic              busy_o,
  output logic              ld_int,
  output logic              ld_p,
  output logic              ld_x,
  output logic              mark_t,
  output logic              mark_x,
  output logic              ret_ld,
  output logic              ret_ie,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [NIB_W-1:0]  mem_reg_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [NIB_W-1:0]  reg_idx_o,
  output logic              reg_inc_o,
  output logic              reg_dec_o
);

  localparam logic [NIB_W-1:0] STACK_V = NIB_W'(STACK_REG);

  seq_st_t  st_q;
  op_kind_t kind_q;
  logic     idle;
  logic     take_op;

  assign idle       = (st_q == ST_IDLE);
  assign op_ready_o = idle && !(irq_i && ie_i);
  assign take_op    = op_ready_o && op_valid_i;

  // Control pulses to the designator registers.
  assign ld_int = idle && irq_i && ie_i;
  assign ld_p   = take_op && (kind_i == OP_SEP);
  assign ld_x   = take_op && (kind_i == OP_SEX);
  assign mark_t = take_op && (kind_i == OP_MARK);
  assign mark_x = (st_q == ST_WR) && (kind_q == OP_MARK);
  assign ret_ld = (st_q == ST_INC);
  assign ret_ie = (kind_q == OP_RET);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      kind_q      <= OP_NONE;
      busy_o      <= 1'b0;
      mem_rd_o    <= 1'b0;
      mem_wr_o    <= 1'b0;
      mem_reg_o   <= '0;
      mem_wdata_o <= '0;
      reg_idx_o   <= '0;
      reg_inc_o   <= 1'b0;
      reg_dec_o   <= 1'b0;
    end else begin
      mem_rd_o  <= 1'b0;
      mem_wr_o  <= 1'b0;
      reg_inc_o <= 1'b0;
      reg_dec_o <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (take_op) begin
            kind_q <= kind_i;
            case (kind_i)
              OP_MARK: begin
                st_q        <= ST_WR;
                busy_o      <= 1'b1;
                mem_wr_o    <= 1'b1;
                mem_reg_o   <= STACK_V;
                mem_wdata_o <= {x_i, p_i};
              end
              OP_SAV: begin
                st_q        <= ST_WR;
                busy_o      <= 1'b1;
                mem_wr_o    <= 1'b1;
                mem_reg_o   <= x_i;
                mem_wdata_o <= t_i;
              end
              OP_RET, OP_DIS: begin
                st_q      <= ST_RD;
                busy_o    <= 1'b1;
                mem_rd_o  <= 1'b1;
                mem_reg_o <= x_i;
              end
              default: ;
            endcase
          end
        end
        ST_WR: begin
          if (kind_q == OP_MARK) begin
            st_q      <= ST_DEC;
            reg_dec_o <= 1'b1;
            reg_idx_o <= STACK_V;
          end else begin
            st_q   <= ST_IDLE;
            busy_o <= 1'b0;
          end
        end
        ST_DEC: begin
          st_q   <= ST_IDLE;
          busy_o <= 1'b0;
        end
        ST_RD: begin
          // X is still the old value here; the read data arrives next cycle.
          st_q      <= ST_INC;
          reg_inc_o <= 1'b1;
          reg_idx_o <= x_i;
        end
        ST_INC: begin
          st_q   <= ST_IDLE;
          busy_o <= 1'b0;
        end
        default: begin
          st_q   <= ST_IDLE;
          busy_o <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/pxlink_ctrl.sv
module pxlink_ctrl
  import pxl_pkg::*;
#(
  parameter int NIB_W     = 4,
  parameter int INT_P     = 1,
  parameter int INT_X     = 2,
  parameter int STACK_REG = 2,
  parameter bit RST_IE    = 1'b1,
  localparam int DATA_W = 2 * NIB_W,
  localparam int OP_W   = NIB_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_i,
  input  logic              op_valid_i,
  input  logic [OP_W-1:0]   op_i,
  output logic              op_ready_o,
  output logic              busy_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [NIB_W-1:0]  mem_reg_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [NIB_W-1:0]  reg_idx_o,
  output logic              reg_inc_o,
  output logic              reg_dec_o,
  output logic [NIB_W-1:0]  p_o,
  output logic [NIB_W-1:0]  x_o,
  output logic [DATA_W-1:0] t_o,
  output logic              ie_o
);

  op_kind_t         kind;
  logic [NIB_W-1:0] n_fld;
  logic ld_int, ld_p, ld_x, mark_t, mark_x, ret_ld, ret_ie;

  pxl_decode #(.NIB_W(NIB_W)) u_dec (
    .op_i   (op_i),
    .kind_o (kind),
    .n_o    (n_fld)
  );

  pxl_seq #(.NIB_W(NIB_W), .STACK_REG(STACK_REG)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .op_valid_i  (op_valid_i),
    .kind_i      (kind),
    .irq_i       (irq_i),
    .ie_i        (ie_o),
    .p_i         (p_o),
    .x_i         (x_o),
    .t_i         (t_o),
    .op_ready_o  (op_ready_o),
    .busy_o      (busy_o),
    .ld_int      (ld_int),
    .ld_p        (ld_p),
    .ld_x        (ld_x),
    .mark_t      (mark_t),
    .mark_x      (mark_x),
    .ret_ld      (ret_ld),
    .ret_ie      (ret_ie),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_reg_o   (mem_reg_o),
    .mem_wdata_o (mem_wdata_o),
    .reg_idx_o   (reg_idx_o),
    .reg_inc_o   (reg_inc_o),
    .reg_dec_o   (reg_dec_o)
  );

  pxl_regs #(
    .NIB_W(NIB_W), .INT_P(INT_P), .INT_X(INT_X), .RST_IE(RST_IE)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .ld_int  (ld_int),
    .ld_p    (ld_p),
    .ld_x    (ld_x),
    .mark_t  (mark_t),
    .mark_x  (mark_x),
    .ret_ld  (ret_ld),
    .ret_ie  (ret_ie),
    .n_i     (n_fld),
    .rdata_i (mem_rdata_i),
    .p_o     (p_o),
    .x_o     (x_o),
    .t_o     (t_o),
    .ie_o    (ie_o)
  );

endmodule

// File: rtl/pxlink_ctrl_chk.sv
module pxlink_ctrl_chk #(
  parameter int NIB_W     = 4,
  parameter int INT_P     = 1,
  parameter int INT_X     = 2,
  parameter int STACK_REG = 2,
  parameter bit RST_IE    = 1'b1,
  localparam int DATA_W = 2 * NIB_W,
  localparam int OP_W   = NIB_W + 4
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_i,
  input logic              op_valid_i,
  input logic [OP_W-1:0]   op_i,
  input logic              op_ready_o,
  input logic              busy_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [NIB_W-1:0]  mem_reg_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic [NIB_W-1:0]  reg_idx_o,
  input logic              reg_inc_o,
  input logic              reg_dec_o,
  input logic [NIB_W-1:0]  p_o,
  input logic [NIB_W-1:0]  x_o,
  input logic [DATA_W-1:0] t_o,
  input logic              ie_o
);

  localparam logic [NIB_W-1:0] INT_P_V = NIB_W'(INT_P);
  localparam logic [NIB_W-1:0] INT_X_V = NIB_W'(INT_X);
  localparam logic [NIB_W-1:0] STACK_V = NIB_W'(STACK_REG);

  // R1: state right after a reset cycle
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (p_o == '0 && x_o == '0 && t_o == '0 && ie_o == RST_IE &&
                    !busy_o && !mem_rd_o && !mem_wr_o && !reg_inc_o && !reg_dec_o));

  // R3: entry state one edge after an enabled request at an idle boundary
  p_int_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && irq_i && ie_o) |=>
      (p_o == INT_P_V && x_o == INT_X_V && !ie_o && t_o == $past({x_o, p_o})));

  // R4: a decrement always follows a write through the stack register
  p_dec_after_wr_r4: assert property (@(posedge clk) disable iff (rst)
    reg_dec_o |-> ($past(mem_wr_o) && $past(mem_reg_o) == reg_idx_o && reg_idx_o == STACK_V));

  // R6: an increment always follows a read through the same register
  p_inc_after_rd_r6: assert property (@(posedge clk) disable iff (rst)
    reg_inc_o |-> ($past(mem_rd_o) && $past(mem_reg_o) == reg_idx_o));

  // R7: a masked request on an idle, opcode-free cycle changes nothing
  p_masked_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !ie_o && !op_valid_i) |=>
      ($stable(p_o) && $stable(x_o) && $stable(t_o) && $stable(ie_o)));

  // R10: strobes never overlap
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    $countones({mem_rd_o, mem_wr_o, reg_inc_o, reg_dec_o}) <= 1);

  // R10: no acceptance during a sequence
  p_no_ready_busy_r10: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !op_ready_o);

endmodule

bind pxlink_ctrl pxlink_ctrl_chk #(
  .NIB_W(NIB_W), .INT_P(INT_P), .INT_X(INT_X),
  .STACK_REG(STACK_REG), .RST_IE(RST_IE)
) u_chk (.*);

// File: tb/pxlink_ctrl_tb.sv
module pxlink_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       irq_i = 1'b0;
  logic       op_valid_i = 1'b0;
  logic [7:0] op_i = 8'h00;
  logic       op_ready_o, busy_o;
  logic       mem_rd_o, mem_wr_o;
  logic [3:0] mem_reg_o;
  logic [7:0] mem_wdata_o;
  logic [7:0] mem_rdata_i = 8'h00;
  logic [3:0] reg_idx_o;
  logic       reg_inc_o, reg_dec_o;
  logic [3:0] p_o, x_o;
  logic [7:0] t_o;
  logic       ie_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [7:0] rd_val = 8'h00;

  // Expected command events: {kind[3:0], reg[3:0], data[7:0]}
  // kind 1 = write, 2 = read, 3 = increment, 4 = decrement
  logic [15:0] exp_q[$];

  always #4 clk = ~clk;

  pxlink_ctrl u_dut (
    .clk(clk), .rst(rst), .irq_i(irq_i), .op_valid_i(op_valid_i), .op_i(op_i),
    .op_ready_o(op_ready_o), .busy_o(busy_o),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_reg_o(mem_reg_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .reg_idx_o(reg_idx_o), .reg_inc_o(reg_inc_o), .reg_dec_o(reg_dec_o),
    .p_o(p_o), .x_o(x_o), .t_o(t_o), .ie_o(ie_o)
  );

  // Memory model: data only in the cycle after a read strobe.
  always @(posedge clk) mem_rdata_i <= mem_rd_o ? rd_val : 8'h00;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compare every produced command with the queue head.
  always @(negedge clk) begin
    if (!rst && (mem_wr_o || mem_rd_o || reg_inc_o || reg_dec_o)) begin
      logic [15:0] act;
      logic [15:0] e;
      if (mem_wr_o)       act = {4'd1, mem_reg_o, mem_wdata_o};
      else if (mem_rd_o)  act = {4'd2, mem_reg_o, 8'h00};
      else if (reg_inc_o) act = {4'd3, reg_idx_o, 8'h00};
      else                act = {4'd4, reg_idx_o, 8'h00};
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected command event", {16'h0, act}, 32'h0);
      end else begin
        e = exp_q.pop_front();
        check(act == e, "R4/R5/R6 command order and content", {16'h0, act}, {16'h0, e});
      end
    end
  end

  // Driver: offer an opcode, wait for acceptance and completion, count busy cycles.
  task automatic run_op(input logic [7:0] op, input int exp_busy, input string tag);
    int n;
    @(negedge clk);
    op_valid_i = 1'b1;
    op_i = op;
    #1;
    while (!op_ready_o) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    op_valid_i = 1'b0;
    n = 0;
    while (busy_o) begin
      n++;
      @(negedge clk);
    end
    check(n == exp_busy, tag, n, exp_busy);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(p_o == 4'h0 && x_o == 4'h0, "R1 reset P/X", {p_o, x_o}, 0);
    check(t_o == 8'h00 && ie_o == 1'b1 && !busy_o, "R1 reset T/IE/busy", {t_o, ie_o, busy_o}, 9'h002);

    // R2 set-P / set-X
    run_op(8'hDF, 0, "R2 set-P busy cycles");
    check(p_o == 4'hF, "R2 set-P N=F", p_o, 4'hF);
    run_op(8'hD5, 0, "R2 set-P busy cycles");
    check(p_o == 4'h5, "R2 set-P N=5", p_o, 4'h5);
    run_op(8'hE3, 0, "R2 set-X busy cycles");
    check(x_o == 4'h3 && p_o == 4'h5, "R2 set-X N=3", {x_o, p_o}, 8'h35);

    // R4 link
    exp_q.push_back({4'd1, 4'd2, 8'h35});
    exp_q.push_back({4'd4, 4'd2, 8'h00});
    run_op(8'h79, 2, "R4 link busy cycles");
    check(t_o == 8'h35, "R4 link T", t_o, 8'h35);
    check(x_o == 4'h5 && p_o == 4'h5, "R4 link X=P", {x_o, p_o}, 8'h55);

    // R5 save
    run_op(8'hE7, 0, "R2 set-X busy cycles");
    exp_q.push_back({4'd1, 4'd7, 8'h35});
    run_op(8'h78, 1, "R5 save busy cycles");
    check(p_o == 4'h5 && x_o == 4'h7 && t_o == 8'h35 && ie_o,
          "R5 save leaves state", {ie_o, t_o, x_o, p_o}, 17'h13575);

    // R6 return
    rd_val = 8'h9C;
    exp_q.push_back({4'd2, 4'd7, 8'h00});
    exp_q.push_back({4'd3, 4'd7, 8'h00});
    run_op(8'h70, 2, "R6 return busy cycles");
    check(x_o == 4'h9 && p_o == 4'hC && ie_o == 1'b1, "R6 return load", {ie_o, x_o, p_o}, 9'h19C);

    // R6 return-disabled
    run_op(8'hEA, 0, "R2 set-X busy cycles");
    rd_val = 8'h4B;
    exp_q.push_back({4'd2, 4'hA, 8'h00});
    exp_q.push_back({4'd3, 4'hA, 8'h00});
    run_op(8'h71, 2, "R6 return-disabled busy cycles");
    check(x_o == 4'h4 && p_o == 4'hB && ie_o == 1'b0, "R6 return-disabled load", {ie_o, x_o, p_o}, 9'h04B);

    // R7 masked request ignored
    @(negedge clk);
    irq_i = 1'b1;
    repeat (4) @(negedge clk);
    check(p_o == 4'hB && x_o == 4'h4 && t_o == 8'h35 && !ie_o,
          "R7 masked request", {ie_o, t_o, x_o, p_o}, 17'h0354B);
    irq_i = 1'b0;

    // Re-enable, then R3 entry
    rd_val = 8'h36;
    exp_q.push_back({4'd2, 4'd4, 8'h00});
    exp_q.push_back({4'd3, 4'd4, 8'h00});
    run_op(8'h70, 2, "R6 return busy cycles");
    @(negedge clk);
    irq_i = 1'b1;
    @(negedge clk);
    irq_i = 1'b0;
    check(t_o == 8'h36 && p_o == 4'h1 && x_o == 4'h2 && !ie_o,
          "R3 interrupt entry", {ie_o, t_o, x_o, p_o}, 17'h03621);

    // R7 request raised during a busy sequence is held off
    rd_val = 8'h58;
    exp_q.push_back({4'd2, 4'd2, 8'h00});
    exp_q.push_back({4'd3, 4'd2, 8'h00});
    run_op(8'h70, 2, "R6 return busy cycles");
    exp_q.push_back({4'd1, 4'd5, 8'h36});
    @(negedge clk);
    op_valid_i = 1'b1;
    op_i = 8'h78;
    @(negedge clk);
    op_valid_i = 1'b0;
    irq_i = 1'b1;
    check(busy_o && p_o == 4'h8, "R7 no entry while busy", {busy_o, p_o}, 5'h18);
    @(negedge clk);
    check(!busy_o && p_o == 4'h8 && x_o == 4'h5, "R7 entry deferred to idle", {busy_o, x_o, p_o}, 9'h058);
    @(negedge clk);
    irq_i = 1'b0;
    check(p_o == 4'h1 && x_o == 4'h2 && t_o == 8'h58 && !ie_o,
          "R7 entry taken after sequence", {ie_o, t_o, x_o, p_o}, 17'h05821);

    // R8 interrupt wins over an offered opcode
    rd_val = 8'h2A;
    exp_q.push_back({4'd2, 4'd2, 8'h00});
    exp_q.push_back({4'd3, 4'd2, 8'h00});
    run_op(8'h70, 2, "R6 return busy cycles");
    @(negedge clk);
    op_valid_i = 1'b1;
    op_i = 8'hD7;
    irq_i = 1'b1;
    #1;
    check(!op_ready_o, "R8 ready low during entry", op_ready_o, 0);
    @(negedge clk);
    irq_i = 1'b0;
    check(p_o == 4'h1 && t_o == 8'h2A, "R8 entry before opcode", {t_o, p_o}, 12'h2A1);
    @(negedge clk);
    op_valid_i = 1'b0;
    check(p_o == 4'h7 && x_o == 4'h2, "R8 deferred opcode applied", {x_o, p_o}, 8'h27);

    // R9 unrecognized opcodes
    run_op(8'hC4, 0, "R9 no busy");
    run_op(8'h60, 0, "R9 no busy");
    run_op(8'h7A, 0, "R9 no busy");
    @(negedge clk);
    check(p_o == 4'h7 && x_o == 4'h2 && t_o == 8'h2A && !ie_o,
          "R9 state unchanged", {ie_o, t_o, x_o, p_o}, 17'h02A27);

    check(exp_q.size() == 0, "R10 all expected commands seen", exp_q.size(), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule